// File: doc/BRIEF.md
# Smart-Card Character Transceiver

This block is a half-duplex-friendly asynchronous serial transceiver for card links. Every character is eleven bit periods long: a low start bit, eight data bits, a parity bit and a single high stop bit. A single configuration input picks one of two conventions. The plain convention sends data least-significant bit first, with true levels and even parity. The inverted convention sends data most-significant bit first, with inverted levels and odd parity. Bit timing comes from a prescaled tick at sixteen ticks per bit.

The receiver may find a bad parity while error signalling is enabled. It then pulls the transmit line low for one bit period, so the far end knows it must repeat the character. The transmitter reads the receive line when it finishes a character and reports whether the far end pulled it low. A host loads one character into a single transmit holding register. It takes received characters from a single receive holding register, and it sees sticky error flags plus one-cycle completion pulses.

Top module: `scard_uart`

## Requirements
- R1: With `cfg_inverse`=0 a transmitted character on `txd` is: start bit low, then data bit 0 through data bit 7 at true level, then a parity bit equal to the XOR of the eight data bits (even parity), then a high stop bit.
- R2: With `cfg_inverse`=1 the data bits go out from bit 7 down to bit 0, each at inverted level. The logical parity bit makes the count of ones over data and parity odd, and it is also sent inverted. Start is low and stop is high.
- R3: One bit period lasts 16·(`baud_div`+1)·P clock cycles, where P is 1, 8 or 32 for `clk_sel` values 0, 1 and 2 or 3. `tx_done` comes exactly 176 tick periods after the start bit begins.
- R4: Transmission starts only while `tx_en`=1 and the holding register is full (`tx_empty`=0). `tx_wr` fills the register only while it is empty, and a write while full is ignored. The register empties when its character moves to the shifter.
- R5: `tx_done` is a one-cycle pulse at the end of the stop bit. At that same edge `tx_nack` captures 1 if `rxd` is low, and 0 otherwise.
- R6: With `rx_en`=0 a frame on `rxd` produces no received character, no `rx_int` and no error signal.
- R7: A received character is decoded with the convention that is in force, and it appears on `rx_data`. `rx_ready` goes to 1 with a one-cycle `rx_int`, and `rx_rd` clears `rx_ready`.
- R8: A received parity that breaks the selected convention sets `err_parity`, and the character is still delivered.
- R9: A stop bit that samples low (2-of-3 majority at mid-bit) sets `err_frame`.
- R10: If a character completes while `rx_ready`=1 and `rx_rd` is not asserted, `rx_data` is overwritten, `err_overrun` is set and no `rx_int` is raised.
- R11: `err_sum` is the OR of the three error flags. The flags stay set until `err_clr` clears them.
- R12: On a parity error with `err_sig_en`=1, `txd` goes low for 16 ticks starting at the stop-bit mid-sample. With `err_sig_en`=0 it stays high.
- R13: `txd` idles high when no character is being sent and no error signal is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_inverse | input | 1 | 0 plain convention, 1 inverted convention |
| clk_sel | input | 2 | Prescale select: 0 /1, 1 /8, 2-3 /32 |
| baud_div | input | 8 | Rate divisor n, tick = prescaled clock/(n+1) |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| err_sig_en | input | 1 | Enable parity-error low level on txd |
| tx_wr | input | 1 | Write strobe for the transmit holding register |
| tx_data | input | 8 | Character to send |
| tx_empty | output | 1 | Transmit holding register empty |
| tx_done | output | 1 | Pulse when a character has left the shifter |
| tx_nack | output | 1 | Far end reported an error on the last character |
| rx_rd | input | 1 | Read strobe, clears rx_ready |
| rx_data | output | 8 | Last received character |
| rx_ready | output | 1 | Receive holding register full |
| rx_int | output | 1 | Pulse on a received character (not on overrun) |
| err_clr | input | 1 | Clears all error flags |
| err_overrun | output | 1 | Overrun flag |
| err_frame | output | 1 | Framing error flag |
| err_parity | output | 1 | Parity error flag |
| err_sum | output | 1 | OR of the error flags |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |

## Verification
On every cycle the assertions check the handshake rules. The transmit register fills only through a write. `tx_done` never lasts longer than one cycle. `rx_int` appears only when the receive register was free, and it always leaves `rx_ready` set. A rising overrun never comes with an interrupt, and `err_sum` rises only with a flag behind it. Other behaviour can only be shown by the bench's scenarios. These are the bit order, levels and parity of both conventions on the line, and the exact frame length across prescale settings. They also cover decoding of received frames, the timing window of the low error level on `txd`, and the capture of a far-end error at the end of transmission.

// File: rtl/scard_uart.sv
module scard_uart #(
  parameter int DW   = 8,
  parameter int OVS  = 16,
  parameter int DIVW = 8
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_inverse,
  input  logic [1:0]      clk_sel,
  input  logic [DIVW-1:0] baud_div,
  input  logic            tx_en,
  input  logic            rx_en,
  input  logic            err_sig_en,
  input  logic            tx_wr,
  input  logic [DW-1:0]   tx_data,
  output logic            tx_empty,
  output logic            tx_done,
  output logic            tx_nack,
  input  logic            rx_rd,
  output logic [DW-1:0]   rx_data,
  output logic            rx_ready,
  output logic            rx_int,
  input  logic            err_clr,
  output logic            err_overrun,
  output logic            err_frame,
  output logic            err_parity,
  output logic            err_sum,
  input  logic            rxd,
  output logic            txd
);
  localparam int FB = DW + 3;
  localparam int SW = $clog2(OVS);
  localparam int IW = $clog2(FB);
  localparam int TW = DIVW + 6;
  localparam logic [SW-1:0] VA    = SW'(OVS/2 - 1);
  localparam logic [SW-1:0] VB    = SW'(OVS/2);
  localparam logic [SW-1:0] VC    = SW'(OVS/2 + 1);
  localparam logic [SW-1:0] SLAST = SW'(OVS - 1);
  localparam logic [IW-1:0] ILAST = IW'(FB - 1);

  logic [TW-1:0] tcnt, tlim;
  logic          tick;

  always_comb begin
    case (clk_sel)
      2'd0:    tlim = TW'(baud_div);
      2'd1:    tlim = (TW'(baud_div) << 3) + TW'(7);
      default: tlim = (TW'(baud_div) << 5) + TW'(31);
    endcase
  end

  assign tick = (tcnt >= tlim);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tcnt <= '0;
    else        tcnt <= tick ? '0 : tcnt + 1'b1;

  logic [1:0] rsy;
  logic       rs;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rsy <= 2'b11;
    else        rsy <= {rsy[0], rxd};
  assign rs = rsy[1];

  function automatic logic [FB-1:0] mk_frame(input logic [DW-1:0] d, input logic inv);
    logic [FB-1:0] f;
    logic          p;
    f[0] = 1'b0;
    for (int i = 0; i < DW; i++) f[i+1] = inv ? ~d[DW-1-i] : d[i];
    p = (^d) ^ inv;
    f[DW+1] = inv ? ~p : p;
    f[FB-1] = 1'b1;
    return f;
  endfunction

  logic [DW-1:0] tbuf;
  logic          tfull, tbusy, tstart;
  logic [FB-1:0] tsh;
  logic [SW-1:0] tsub;
  logic [IW-1:0] tidx;

  assign tstart   = tick && !tbusy && tx_en && tfull;
  assign tx_empty = ~tfull;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tbuf <= '0; tfull <= 1'b0; tbusy <= 1'b0; tsh <= '1;
      tsub <= '0; tidx <= '0; tx_done <= 1'b0; tx_nack <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (tx_wr && !tfull) begin
        tbuf  <= tx_data;
        tfull <= 1'b1;
      end
      if (tstart) begin
        tfull <= 1'b0;
        tbusy <= 1'b1;
        tsh   <= mk_frame(tbuf, cfg_inverse);
        tsub  <= '0;
        tidx  <= '0;
      end else if (tbusy && tick) begin
        if (tsub == SLAST) begin
          tsub <= '0;
          if (tidx == ILAST) begin
            tbusy   <= 1'b0;
            tx_done <= 1'b1;
            tx_nack <= ~rs;
          end else begin
            tidx <= tidx + 1'b1;
            tsh  <= {1'b1, tsh[FB-1:1]};
          end
        end else begin
          tsub <= tsub + 1'b1;
        end
      end
    end
  end

  logic          rbusy;
  logic [SW-1:0] rsub;
  logic [IW-1:0] ridx;
  logic [1:0]    rv;
  logic [DW:0]   rsh;
  logic [DW-1:0] rdat;
  logic          rpar, rbad, rmaj;
  logic [SW:0]   ncnt;

  assign rmaj = (rv[0] & rv[1]) | (rs & (rv[0] | rv[1]));

  always_comb begin
    for (int i = 0; i < DW; i++) rdat[i] = cfg_inverse ? ~rsh[DW-1-i] : rsh[i];
    rpar = cfg_inverse ? ~rsh[DW] : rsh[DW];
    rbad = ((^rdat) ^ rpar) != cfg_inverse;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbusy <= 1'b0; rsub <= '0; ridx <= '0; rv <= 2'b11; rsh <= '0;
      ncnt <= '0; rx_data <= '0; rx_ready <= 1'b0; rx_int <= 1'b0;
      err_overrun <= 1'b0; err_frame <= 1'b0; err_parity <= 1'b0;
    end else begin
      rx_int <= 1'b0;
      if (tick && ncnt != '0) ncnt <= ncnt - 1'b1;
      if (rx_rd) rx_ready <= 1'b0;
      if (err_clr) begin
        err_overrun <= 1'b0; err_frame <= 1'b0; err_parity <= 1'b0;
      end
      if (!rbusy) begin
        if (tick && rx_en && !rs) begin
          rbusy <= 1'b1;
          rsub  <= SW'(1);
          ridx  <= '0;
        end
      end else if (tick) begin
        if (rsub == VA) rv[0] <= rs;
        if (rsub == VB) rv[1] <= rs;
        if (rsub == SLAST) begin
          rsub <= '0;
          ridx <= ridx + 1'b1;
        end else begin
          rsub <= rsub + 1'b1;
        end
        if (rsub == VC) begin
          if (ridx == '0) begin
            if (rmaj) rbusy <= 1'b0;
          end else if (ridx == ILAST) begin
            rbusy   <= 1'b0;
            rx_data <= rdat;
            if (rx_ready && !rx_rd) err_overrun <= 1'b1;
            else begin
              rx_ready <= 1'b1;
              rx_int   <= 1'b1;
            end
            if (rbad) begin
              err_parity <= 1'b1;
              if (err_sig_en) ncnt <= (SW+1)'(OVS);
            end
            if (!rmaj) err_frame <= 1'b1;
          end else begin
            rsh <= {rmaj, rsh[DW:1]};
          end
        end
      end
    end
  end

  assign err_sum = err_overrun | err_frame | err_parity;
  assign txd     = (tbusy ? tsh[0] : 1'b1) & (ncnt == '0);
endmodule

// File: rtl/scard_uart_chk.sv
module scard_uart_chk (
  input logic clk,
  input logic rst_n,
  input logic tx_wr,
  input logic tx_empty,
  input logic tx_done,
  input logic rx_rd,
  input logic rx_ready,
  input logic rx_int,
  input logic err_overrun,
  input logic err_frame,
  input logic err_parity,
  input logic err_sum
);
  p_fill_by_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) |-> $past(tx_wr));

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  p_int_sets_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> rx_ready);

  p_int_needs_free_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> (!$past(rx_ready) || $past(rx_rd)));

  p_ovr_no_int_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_overrun) |-> !rx_int);

  p_sum_backed_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_sum) |-> (err_overrun || err_frame || err_parity));
endmodule

bind scard_uart scard_uart_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_empty(tx_empty),
  .tx_done(tx_done), .rx_rd(rx_rd), .rx_ready(rx_ready), .rx_int(rx_int),
  .err_overrun(err_overrun), .err_frame(err_frame), .err_parity(err_parity),
  .err_sum(err_sum)
);

// File: tb/scard_uart_tb.sv
`timescale 1ns/1ps
module scard_uart_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       cfg_inverse = 0, tx_en = 0, rx_en = 0, err_sig_en = 0;
  logic [1:0] clk_sel = 0;
  logic [7:0] baud_div = 0, tx_data = 0;
  logic       tx_wr = 0, rx_rd = 0, err_clr = 0, rxd = 1;
  logic       tx_empty, tx_done, tx_nack, rx_ready, rx_int;
  logic [7:0] rx_data;
  logic       err_overrun, err_frame, err_parity, err_sum, txd;

  scard_uart u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_inverse(cfg_inverse), .clk_sel(clk_sel),
    .baud_div(baud_div), .tx_en(tx_en), .rx_en(rx_en), .err_sig_en(err_sig_en),
    .tx_wr(tx_wr), .tx_data(tx_data), .tx_empty(tx_empty), .tx_done(tx_done),
    .tx_nack(tx_nack), .rx_rd(rx_rd), .rx_data(rx_data), .rx_ready(rx_ready),
    .rx_int(rx_int), .err_clr(err_clr), .err_overrun(err_overrun),
    .err_frame(err_frame), .err_parity(err_parity), .err_sum(err_sum),
    .rxd(rxd), .txd(txd)
  );

  int  checks = 0, fails = 0, ints = 0, tp = 1;
  bit  finished = 0;

  always @(negedge clk) if (rx_int) ints++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [10:0] enc(input logic [7:0] d, input bit inv,
                                      input bit badpar, input bit badstop);
    logic [10:0] b;
    bit p;
    b[0] = 0;
    for (int k = 0; k < 8; k++) b[k+1] = inv ? !d[7-k] : d[k];
    p = inv ? ($countones(d) % 2 == 0) : ($countones(d) % 2 == 1);
    b[9]  = (inv ? !p : p) ^ badpar;
    b[10] = !badstop;
    return b;
  endfunction

  task automatic setcfg(input bit inv, input logic [1:0] sel, input logic [7:0] div);
    cfg_inverse = inv; clk_sel = sel; baud_div = div;
    tp = (int'(div) + 1) * (sel == 0 ? 1 : (sel == 1 ? 8 : 32));
  endtask

  task automatic pulse_rd_clr();
    @(negedge clk); rx_rd = 1; err_clr = 1;
    @(negedge clk); rx_rd = 0; err_clr = 0;
  endtask

  task automatic do_tx(input logic [7:0] d, input bit far_err, input bit wr);
    int el;
    logic [10:0] b;
    @(negedge clk); rx_en = 0;
    if (wr) begin
      tx_wr = 1; tx_data = d;
      @(negedge clk); tx_wr = 0;
      chk("R4 holding register full after write", tx_empty, 0);
    end
    tx_en = 1;
    el = 0;
    while (txd !== 1'b0 && el < 64 * tp + 100) begin @(negedge clk); el++; end
    chk("R4 start bit appears", txd, 0);
    chk("R4 register empties at start", tx_empty, 1);
    repeat (8 * tp) @(negedge clk);
    b[0] = txd;
    for (int k = 1; k < 11; k++) begin
      repeat (16 * tp) @(negedge clk);
      b[k] = txd;
    end
    el = 168 * tp;
    rxd = far_err ? 1'b0 : 1'b1;
    while (!tx_done && el < 400 * tp) begin @(negedge clk); el++; end
    chk("R3 start-to-done length", el, 176 * tp);
    chk("R5 far-end error captured", tx_nack, far_err);
    rxd = 1; tx_en = 0;
    if (cfg_inverse) chk("R2 inverted frame on line", b, enc(d, 1, 0, 0));
    else             chk("R1 plain frame on line", b, enc(d, 0, 0, 0));
    @(negedge clk);
    chk("R5 done lasts one cycle", tx_done, 0);
    chk("R13 line idles high", txd, 1);
  endtask

  task automatic do_rx(input logic [7:0] d, input bit badpar, input bit badstop,
                       input bit exp_nack);
    logic [10:0] b;
    b = enc(d, cfg_inverse, badpar, badstop);
    @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      rxd = b[k];
      repeat (16 * tp) @(negedge clk);
    end
    rxd = 1;
    chk("R12 error level on txd", txd, exp_nack ? 0 : 1);
    repeat (24 * tp) @(negedge clk);
    chk("R12 error level released", txd, 1);
  endtask

  initial begin
    int i0;
    int unsigned seed;
    logic [7:0] d;
    bit inv, bp, fe;
    seed = 32'd7;
    void'($urandom(seed));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R4 reset tx_empty", tx_empty, 1);
    chk("R13 reset txd", txd, 1);
    chk("R7 reset rx_ready", rx_ready, 0);
    chk("R11 reset err_sum", err_sum, 0);
    chk("R5 reset tx_done", tx_done, 0);

    setcfg(0, 0, 0);
    do_tx(8'h3B, 0, 1);
    setcfg(1, 0, 1);
    do_tx(8'h3B, 1, 1);
    setcfg(0, 0, 2);
    do_tx(8'h80, 0, 1);

    @(negedge clk); tx_en = 0; tx_wr = 1; tx_data = 8'hC6;
    @(negedge clk); tx_wr = 0;
    repeat (40 * tp) @(negedge clk);
    chk("R4 no start while disabled", txd, 1);
    chk("R4 register held while disabled", tx_empty, 0);
    tx_wr = 1; tx_data = 8'h11;
    @(negedge clk); tx_wr = 0;
    do_tx(8'hC6, 0, 0);

    setcfg(0, 0, 1);
    rx_en = 1; err_sig_en = 1;
    i0 = ints;
    do_rx(8'h5A, 0, 0, 0);
    chk("R7 plain rx data", rx_data, 8'h5A);
    chk("R7 rx_ready set", rx_ready, 1);
    chk("R7 one rx_int", ints - i0, 1);
    chk("R11 clean frame err_sum", err_sum, 0);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;
    chk("R7 rx_rd clears ready", rx_ready, 0);

    setcfg(1, 0, 0);
    do_rx(8'hE1, 1, 0, 1);
    chk("R8 inverted rx data kept", rx_data, 8'hE1);
    chk("R8 parity flag", err_parity, 1);
    chk("R11 sum follows parity", err_sum, 1);
    @(negedge clk); err_clr = 1; @(negedge clk); err_clr = 0;
    chk("R11 err_clr clears sum", err_sum, 0);
    @(negedge clk); rx_rd = 1; @(negedge clk); rx_rd = 0;

    err_sig_en = 0;
    do_rx(8'h0F, 1, 0, 0);
    chk("R12 flag without line signal", err_parity, 1);
    pulse_rd_clr();
    err_sig_en = 1;

    setcfg(0, 0, 0);
    do_rx(8'h77, 0, 1, 0);
    chk("R9 framing flag", err_frame, 1);
    chk("R9 no parity flag", err_parity, 0);
    pulse_rd_clr();

    i0 = ints;
    do_rx(8'h12, 0, 0, 0);
    do_rx(8'h34, 0, 0, 0);
    chk("R10 newest data kept", rx_data, 8'h34);
    chk("R10 overrun flag", err_overrun, 1);
    chk("R10 no second interrupt", ints - i0, 1);
    chk("R11 sum follows overrun", err_sum, 1);
    pulse_rd_clr();

    rx_en = 0;
    i0 = ints;
    do_rx(8'hAA, 1, 0, 0);
    chk("R6 no character when disabled", rx_ready, 0);
    chk("R6 no interrupt when disabled", ints - i0, 0);
    chk("R6 no flag when disabled", err_sum, 0);
    rx_en = 1;

    setcfg(0, 1, 1);
    do_tx(8'h96, 0, 1);
    setcfg(1, 2, 0);
    do_tx(8'h4D, 1, 1);
    rx_en = 1;
    do_rx(8'h4D, 0, 0, 0);
    chk("R3 slow-clock rx data", rx_data, 8'h4D);
    pulse_rd_clr();

    for (int it = 0; it < 16; it++) begin
      inv = $urandom % 2;
      setcfg(inv, 0, 8'($urandom % 4));
      d  = 8'($urandom);
      fe = $urandom % 2;
      do_tx(d, fe, 1);
      bp = ($urandom % 4) == 0;
      rx_en = 1;
      i0 = ints;
      do_rx(d, bp, 0, bp);
      chk(inv ? "R7 random inverted rx data" : "R7 random plain rx data", rx_data, d);
      chk("R8 random parity flag", err_parity, bp);
      chk("R7 random interrupt", ints - i0, 1);
      pulse_rd_clr();
    end

    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule